// File: doc/BRIEF.md
# Multi-Mode Converter Host Bus Interface

This block sits between a processor bus and an analog-to-digital conversion core. It takes the host's active-low chip select, write and read strobes, together with three strap inputs: a mode pin, a bus-width pin and a byte-select pin. From these it issues one-cycle start pulses to the core. It captures each finished result as a 10-bit code plus an over-range flag. It produces the data word and separate output-enable signals for the low byte and for the high byte. External pads use these enables to drive the bus or release it to high impedance. It also produces a busy flag and that flag's own enable.

Three operating styles come out of the pins. With the mode pin high, the host starts each conversion and can wait on busy. With the mode pin high and all three strobes held low, the block converts without pause and the bytes may be fetched in any order. With the mode pin low and write held low, the block converts without pause regardless of chip select. In that style a byte-wide host must fetch the high byte first, because that read freezes the result until the low byte has been fetched. All strobes and the byte-select are synchronised to the converter clock before use. The core answers each start with a one-cycle done pulse that carries the code.

Top module: `adc_host_if`

## Requirements
- R1: During and right after reset, `conv_start`, `busy_oe`, `dout_hi_oe` and `dout_lo_oe` are 0, `busy` is 1 with the mode pin high, and `dout` is all zeros.
- R2: With the mode pin high and chip select low, one write low pulse yields exactly one single-cycle `conv_start`. `busy` then reads 0 until the core's done pulse and 1 afterwards.
- R3: With the mode pin high, a write pulse while chip select is high starts nothing.
- R4: A write falling edge that arrives while a conversion is running is remembered, and it produces exactly one further conversion once the running one ends.
- R5: With the mode pin high, chip select low and write held low, conversions follow one another back to back.
- R6: `busy_oe` is 0 exactly when the synchronised chip select and read are both high.
- R7: With the bus-width pin high and chip select and read low, both enables are 1. `dout[9:0]` carries the code and `dout[10]` the over-range flag.
- R8: With the bus-width pin low and a read active, byte-select 1 enables only the high byte (`dout[10:8]`) and byte-select 0 only the low byte (`dout[7:0]`). With chip select or read high, neither enable is set.
- R9: `dout` takes every new result at the done pulse, so with read held low it shows each successive conversion.
- R10: With the mode pin low and write low, conversions continue while chip select is high. `busy` is 0 whenever its enable is set, and chip select high keeps both data enables at 0.
- R11: With the mode pin low and a byte-wide bus, a high-byte read freezes `dout` until a low-byte read has ended. Results finishing meanwhile are discarded, not queued.
- R12: With the mode pin low and a byte-wide bus, a result whose done pulse falls in the first cycle a high-byte read is seen is discarded.
- R13: With the mode pin high and all strobes low, conversions run without pause, `busy` is 0, and a high-byte read does not freeze `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, starts conversions |
| rd_n | input | 1 | Read strobe, active low |
| slow_mode | input | 1 | Mode strap: 1 host-started or free-running with strobes low, 0 free-running |
| wide_bus | input | 1 | Bus-width strap: 1 word-wide, 0 byte-wide |
| hi_sel | input | 1 | Byte select on a byte-wide bus: 1 high, 0 low |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_done | input | 1 | One-cycle end-of-conversion pulse from the core |
| conv_code | input | DATA_W | Result code, valid with conv_done |
| conv_ovr | input | 1 | Over-range flag, valid with conv_done |
| dout | output | DATA_W+1 | Latched result: {over-range, code} |
| dout_hi_oe | output | 1 | Enable for dout[10:8] |
| dout_lo_oe | output | 1 | Enable for dout[7:0] |
| busy | output | 1 | 0 while converting in host-started operation |
| busy_oe | output | 1 | Enable for busy |

## Verification
The collision that matters is a core done pulse landing in the same cycle that the result latch starts to freeze for a high-byte read. The bench measures the fixed spacing of done pulses in free-running operation and places the read strobe two clocks ahead of a predicted done pulse, so the synchronised read and the done pulse reach the latch on one edge. It confirms that the done pulse did occur in that cycle and then requires `dout` to keep the earlier result. A second collision, a write edge during a running conversion, is judged by counting start pulses.

// File: rtl/adc_hif_pkg.sv
// Package: shared types for the converter host interface.
// Assumes: strobes given to decode_mode are already synchronised, active low.
package adc_hif_pkg;

    typedef enum logic [1:0] {
        MODE_SLOW = 2'd0,   // host-started conversions, busy is meaningful
        MODE_FAST = 2'd1,   // free-running, byte reads must go high first
        MODE_DMA  = 2'd2    // free-running with all strobes tied active
    } hif_mode_e;

    // Decode the operating style from the strap and the synchronised strobes.
    function automatic hif_mode_e decode_mode(input logic slow_pin,
                                              input logic cs_n,
                                              input logic wr_n,
                                              input logic rd_n);
        if (!slow_pin)
            return MODE_FAST;
        else if (!cs_n && !wr_n && !rd_n)
            return MODE_DMA;
        else
            return MODE_SLOW;
    endfunction

endpackage

// File: rtl/adc_hif_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each bit is independent; the reset value is given per bit.
module adc_hif_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= din;
            end
        end else begin : g_next
            // Later stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/adc_hif_start.sv
// Module: conversion start control and busy flag.
// Assumes: synchronised active-low strobes. The core answers each start
// with exactly one done pulse, and never in the cycle of the start itself.
module adc_hif_start
    import adc_hif_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hif_mode_e mode,
    input  logic      cs_s,
    input  logic      wr_s,
    input  logic      conv_done,
    output logic      conv_start,
    output logic      in_conv,
    output logic      busy
);

    logic qual_low;   // write request qualified for the current mode
    logic qual_prev;  // previous value, for falling-edge detection
    logic trig;       // an edge seen while busy, waiting to start
    logic issue;      // start a conversion on the next edge

    // Write counts when low, and also needs chip select except free-running.
    always_comb qual_low = !wr_s && ((mode == MODE_FAST) || !cs_s);

    // Start when idle and either a stored edge or a held write asks for it.
    always_comb issue = !in_conv && !conv_start && (trig || qual_low);

    // Edge memory, start pulse and conversion-in-progress state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_prev  <= 1'b0;
            trig       <= 1'b0;
            conv_start <= 1'b0;
            in_conv    <= 1'b0;
        end else begin
            qual_prev  <= qual_low;
            conv_start <= issue;
            if (issue)
                trig <= 1'b0;
            else if (qual_low && !qual_prev)
                trig <= 1'b1;
            if (conv_start)
                in_conv <= 1'b1;
            else if (conv_done)
                in_conv <= 1'b0;
        end
    end

    // Busy is only reported in host-started operation; else it reads low.
    always_comb busy = (mode == MODE_SLOW) ? !(in_conv || conv_start) : 1'b0;

endmodule

// File: rtl/adc_hif_latch.sv
// Module: output result latch with high-byte-first freeze.
// Assumes: hi_read and lo_read come from synchronised strobes; freeze_en is
// set only for free-running operation on a byte-wide bus.
module adc_hif_latch #(
    parameter int DATA_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            freeze_en,
    input  logic            hi_read,
    input  logic            lo_read,
    input  logic            conv_done,
    input  logic [DATA_W-1:0] conv_code,
    input  logic            conv_ovr,
    output logic [DATA_W:0] result,
    output logic            frozen
);

    logic lo_prev;   // low-byte read was active last cycle
    logic block;     // updates inhibited this cycle

    // A high-byte read blocks updates from its first cycle on.
    always_comb block = frozen || (freeze_en && hi_read);

    // Freeze state and result capture; a blocked result is simply dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            frozen  <= 1'b0;
            lo_prev <= 1'b0;
        end else begin
            lo_prev <= lo_read;
            if (!freeze_en)
                frozen <= 1'b0;
            else if (hi_read)
                frozen <= 1'b1;
            else if (lo_prev && !lo_read)
                frozen <= 1'b0;
            if (conv_done && !block)
                result <= {conv_ovr, conv_code};
        end
    end

endmodule

// File: rtl/adc_host_if.sv
// Module: top of the converter host interface.
// Does: synchronises the strobes, decodes the operating style, drives
// conversion starts and busy, latches results and makes the byte enables.
// Assumes: slow_mode and wide_bus are static straps; pads apply the enables.
module adc_host_if
    import adc_hif_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              slow_mode,
    input  logic              wide_bus,
    input  logic              hi_sel,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code,
    input  logic              conv_ovr,
    output logic [DATA_W:0]   dout,
    output logic              dout_hi_oe,
    output logic              dout_lo_oe,
    output logic              busy,
    output logic              busy_oe
);

    localparam int NSYNC = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0111;

    logic [NSYNC-1:0] raw_in, syn;
    logic cs_s, wr_s, rd_s, hi_s;
    hif_mode_e mode;
    logic read_act, hi_read, lo_read, freeze_en;
    logic in_conv_w, frozen_w;

    assign raw_in = {hi_sel, rd_n, wr_n, cs_n};

    adc_hif_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn)
    );

    assign {hi_s, rd_s, wr_s, cs_s} = syn;

    // Operating style and read decode from synchronised strobes.
    always_comb begin
        mode      = decode_mode(slow_mode, cs_s, wr_s, rd_s);
        read_act  = !cs_s && !rd_s;
        hi_read   = read_act && !wide_bus && hi_s;
        lo_read   = read_act && !wide_bus && !hi_s;
        freeze_en = (mode == MODE_FAST) && !wide_bus;
    end

    adc_hif_start start_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .cs_s       (cs_s),
        .wr_s       (wr_s),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .in_conv    (in_conv_w),
        .busy       (busy)
    );

    adc_hif_latch #(
        .DATA_W (DATA_W)
    ) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_en (freeze_en),
        .hi_read   (hi_read),
        .lo_read   (lo_read),
        .conv_done (conv_done),
        .conv_code (conv_code),
        .conv_ovr  (conv_ovr),
        .result    (dout),
        .frozen    (frozen_w)
    );

    // Output enables for the two byte lanes and for the busy pin.
    always_comb begin
        dout_hi_oe = read_act && (wide_bus || hi_s);
        dout_lo_oe = read_act && (wide_bus || !hi_s);
        busy_oe    = !(cs_s && rd_s);
    end

endmodule

// File: rtl/adc_host_if_chk.sv
// Module: property checker for adc_host_if, attached by bind below.
// Assumes: reset is synchronous and active low.
module adc_host_if_chk #(
    parameter int DATA_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            slow_mode,
    input logic            wide_bus,
    input logic            conv_start,
    input logic            in_conv,
    input logic            frozen,
    input logic            busy,
    input logic            busy_oe,
    input logic            oe_hi,
    input logic            oe_lo,
    input logic [DATA_W:0] dout
);

    // R2: a start request is a single-cycle pulse.
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4: no new start is issued while a conversion is running.
    p_no_start_in_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_conv |-> !conv_start);

    // R8: on a byte-wide bus the two lanes are never enabled together.
    p_byte_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_bus |-> !(oe_hi && oe_lo));

    // R7: on a word-wide bus the lanes are enabled as a pair.
    p_wide_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_bus && (oe_hi || oe_lo)) |-> (oe_hi && oe_lo));

    // R6: any data enable implies the busy enable.
    p_oe_busyoe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hi || oe_lo) |-> busy_oe);

    // R10: in free-running operation busy reads low when driven.
    p_fast_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_mode && busy_oe) |-> !busy);

    // R11: a frozen latch keeps its word across the next edge.
    p_freeze_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(dout));

endmodule

bind adc_host_if adc_host_if_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_mode  (slow_mode),
    .wide_bus   (wide_bus),
    .conv_start (conv_start),
    .in_conv    (in_conv_w),
    .frozen     (frozen_w),
    .busy       (busy),
    .busy_oe    (busy_oe),
    .oe_hi      (dout_hi_oe),
    .oe_lo      (dout_lo_oe),
    .dout       (dout)
);

// File: tb/adc_host_if_tb.sv
`timescale 1ns/1ps
// Bench: drives host strobes, models the conversion core, checks ports.
module adc_host_if_tb_top;

    localparam int DATA_W = 10;
    localparam int LAT    = 6;

    logic clk = 1'b0;
    logic rst_n, cs_n, wr_n, rd_n, slow_mode, wide_bus, hi_sel;
    logic conv_start, conv_done, conv_ovr;
    logic [DATA_W-1:0] conv_code;
    logic [DATA_W:0] dout;
    logic dout_hi_oe, dout_lo_oe, busy, busy_oe;

    int tests = 0;
    int fails = 0;
    int start_count = 0;
    int done_count = 0;
    logic [DATA_W:0] last_word = '0;
    logic [DATA_W-1:0] core_code = 10'h003;
    int cnt = 0;

    always #2.5 clk = ~clk;

    adc_host_if #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .slow_mode(slow_mode), .wide_bus(wide_bus), .hi_sel(hi_sel),
        .conv_start(conv_start), .conv_done(conv_done), .conv_code(conv_code),
        .conv_ovr(conv_ovr), .dout(dout), .dout_hi_oe(dout_hi_oe),
        .dout_lo_oe(dout_lo_oe), .busy(busy), .busy_oe(busy_oe)
    );

    // Core model: answers each start with one done pulse LAT cycles later.
    initial begin
        conv_done = 1'b0; conv_code = '0; conv_ovr = 1'b0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    conv_done = 1'b1;
                    conv_code = core_code;
                    conv_ovr  = core_code[1];
                    last_word = {core_code[1], core_code};
                    done_count++;
                    core_code = core_code + 10'd37;
                end
            end
            if (conv_start) begin
                cnt = LAT;
                start_count++;
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_wr();
        wr_n = 1'b0; tick(2); wr_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            tick(1);
            if (conv_done) return;
        end
        chk("wait_done timeout", 0, 1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    // {wide, hi_sel, cs_n, rd_n, exp_hi_oe, exp_lo_oe, exp_busy_oe}
    localparam logic [6:0] VEC [8] = '{
        7'b1000_111, 7'b1100_111, 7'b0100_101, 7'b0000_011,
        7'b0110_001, 7'b0001_001, 7'b1011_000, 7'b0111_000
    };

    initial begin
        int s0, p, d0;
        logic [DATA_W:0] exp_w;
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        slow_mode = 1'b1; wide_bus = 1'b1; hi_sel = 1'b0;
        tick(4);
        // R1: reset state
        chk("R1 conv_start", conv_start, 0);
        chk("R1 busy_oe", busy_oe, 0);
        chk("R1 oe", {dout_hi_oe, dout_lo_oe}, 0);
        chk("R1 busy", busy, 1);
        chk("R1 dout", dout, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 after release", {conv_start, busy_oe, busy}, 3'b001);

        // Table walk: enables for R6, R7, R8
        for (int i = 0; i < 8; i++) begin
            {wide_bus, hi_sel, cs_n, rd_n} = VEC[i][6:3];
            tick(3);
            chk(VEC[i][6] ? "R7 hi_oe" : "R8 hi_oe", dout_hi_oe, VEC[i][2]);
            chk(VEC[i][6] ? "R7 lo_oe" : "R8 lo_oe", dout_lo_oe, VEC[i][1]);
            chk("R6 busy_oe", busy_oe, VEC[i][0]);
        end

        // R2 / R7 / R9: host-started conversion with read held low
        wide_bus = 1'b1; cs_n = 1'b0; rd_n = 1'b0; tick(3);
        s0 = start_count;
        pulse_wr();
        tick(2);
        chk("R2 busy low during conversion", busy, 0);
        tick(10);
        chk("R2 one start", start_count - s0, 1);
        chk("R2 busy high after done", busy, 1);
        chk("R7 R9 dout word", dout, last_word);
        exp_w = last_word;
        pulse_wr(); tick(14);
        chk("R9 refresh with read held", dout, last_word);
        chk("R9 new word differs", (dout != exp_w), 1);

        // R4: second edge during a running conversion
        s0 = start_count;
        pulse_wr(); tick(3);
        pulse_wr(); tick(30);
        chk("R4 deferred start once", start_count - s0, 2);

        // R3: chip select high blocks the start
        cs_n = 1'b1; rd_n = 1'b1; tick(3);
        s0 = start_count;
        pulse_wr(); tick(14);
        chk("R3 no start", start_count - s0, 0);

        // R5: held write gives back-to-back conversions
        cs_n = 1'b0; tick(2);
        s0 = start_count;
        wr_n = 1'b0; tick(40);
        wr_n = 1'b1; tick(14);
        chk("R5 back to back", (start_count - s0 >= 3), 1);

        // R10: free-running with chip select high
        cs_n = 1'b1; rd_n = 1'b1; slow_mode = 1'b0; wr_n = 1'b0; tick(3);
        s0 = start_count;
        tick(40);
        chk("R10 runs with cs high", (start_count - s0 >= 3), 1);
        chk("R10 busy_oe off", busy_oe, 0);
        rd_n = 1'b0; tick(3);
        chk("R10 busy low", {busy_oe, busy}, 2'b10);
        chk("R10 read blocked", {dout_hi_oe, dout_lo_oe}, 0);

        // R11: high-byte read freezes, low-byte read releases
        rd_n = 1'b1; cs_n = 1'b0; wide_bus = 1'b0; tick(3);
        wait_done();
        exp_w = last_word; d0 = done_count;
        hi_sel = 1'b1; rd_n = 1'b0;
        tick(30);
        chk("R11 results produced", (done_count - d0 >= 2), 1);
        chk("R11 frozen hi read", dout, exp_w);
        rd_n = 1'b1; tick(3);
        hi_sel = 1'b0; rd_n = 1'b0; tick(3);
        chk("R11 frozen during lo read", dout, exp_w);
        rd_n = 1'b1; tick(4);
        wait_done(); tick(2);
        chk("R11 update after lo read", dout, last_word);

        // R12: done in the first cycle of a high-byte read is dropped
        wait_done();
        p = 0;
        for (int i = 0; i < 200; i++) begin
            tick(1); p++;
            if (conv_done) break;
        end
        tick(2);
        exp_w = last_word;
        tick(p - 4);
        hi_sel = 1'b1; rd_n = 1'b0;
        tick(2);
        chk("R12 done coincides", conv_done, 1);
        tick(2);
        chk("R12 coincident result dropped", dout, exp_w);
        rd_n = 1'b1; tick(3);
        hi_sel = 1'b0; rd_n = 1'b0; tick(3);
        rd_n = 1'b1; tick(4);

        // R13: strobes tied low with mode pin high
        slow_mode = 1'b1; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; hi_sel = 1'b1;
        tick(3);
        s0 = start_count;
        wait_done(); tick(2);
        chk("R13 hi read no freeze", dout, last_word);
        chk("R13 busy low", busy, 0);
        tick(30);
        chk("R13 continuous", (start_count - s0 >= 3), 1);
        hi_sel = 1'b0; tick(3); hi_sel = 1'b1;
        wait_done(); tick(2);
        chk("R13 any byte order", dout, last_word);

        finish_run();
    end

endmodule